// File: doc/BRIEF.md
# Condition Register Update Unit

This block owns a 32-bit condition register split into eight 4-bit fields and applies the register-side effect of every instruction that writes it. It produces compare results (signed or unsigned, against a second register or a 16-bit immediate) and places them in one chosen field. It also computes a Boolean function of two single condition bits into a third bit, copies one field onto another, loads selected fields from a general register, and records whether a conditional store completed.

Field and bit numbering run from the most significant end. Field 0 is the top nibble, and condition bit n lives at physical position 31-n. The only exception is the masked load, whose mask bit i selects physical bits 4i+3..4i. The register contents are always visible on `cr_out`. An update presented with `op_valid` takes effect on the next rising edge, so any read in the same cycle returns the value from before that update.

Top module: `cond_reg_unit`

## Requirements
- R1: An active-low reset clears the whole register to 0x00000000.
- R2: A compare yields the 4-bit field {LT, GT, EQ, SO} from bit 3 down to bit 0. Exactly one of LT, GT and EQ is set, and SO equals `sum_ovf`.
- R3: Op code 1 compares `opnd_a` with `opnd_b` as signed two's-complement values.
- R4: Op code 2 compares `opnd_a` with `opnd_b` as unsigned values.
- R5: Op code 3 compares `opnd_a`, signed, against `imm16` sign-extended. Op code 4 compares `opnd_a`, unsigned, against `imm16` zero-extended.
- R6: A compare writes only field `fld_dst`, where field k is physical bits 31-4k..28-4k. The other seven fields keep their values.
- R7: Op codes 8 to 15 write one bit. That bit is f(bit `bit_a`, bit `bit_b`) into bit `bit_dst`, and bit n is physical position 31-n. The functions are 8 AND, 9 OR, 10 NAND, 11 XOR, 12 NOR, 13 equivalence, 14 a AND NOT b, and 15 a OR NOT b. All other bits are unchanged.
- R8: Op code 5 copies field `fld_src` into field `fld_dst`.
- R9: Op code 6 takes physical bits 4i+3..4i from `opnd_a` for every set bit i of `fld_mask`. Groups whose mask bit is clear keep their old value, so a zero mask changes nothing.
- R10: Op code 7 writes field 0 as {0, 0, `store_ok`, `sum_ovf`} and leaves bits 27..0 unchanged.
- R11: An update is visible on `cr_out` only after the rising edge that accepts it. Op code 0, or any op code with `op_valid` low, leaves the register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Qualifies the operation in this cycle |
| op_code | input | 4 | Operation selector (see requirements) |
| opnd_a | input | 32 | First operand / masked-write source |
| opnd_b | input | 32 | Second operand for register compares |
| imm16 | input | 16 | Immediate for immediate compares |
| fld_dst | input | 3 | Destination field number |
| fld_src | input | 3 | Source field number for copy |
| bit_dst | input | 5 | Destination condition-bit number |
| bit_a | input | 5 | First source condition-bit number |
| bit_b | input | 5 | Second source condition-bit number |
| fld_mask | input | 8 | Per-group write mask for masked write |
| sum_ovf | input | 1 | Current summary-overflow bit |
| store_ok | input | 1 | Conditional store completed |
| cr_out | output | 32 | Current register contents |

## Verification
The bench builds the unit with its default parameters: eight fields of four bits and a 16-bit immediate. These defaults make every field number, every bit number from 0 to 31, and both immediate extensions reachable with literal expected values.

The operands are chosen so that a signed and an unsigned reading of the same pattern disagree. With these operands, swapping the extension or the signedness changes the stored field. Field 0, field 7, bit 0 and bit 31 are all written, so a reversed numbering shows up in the result.

// File: rtl/crf_pkg.sv
package crf_pkg;

  typedef enum logic [3:0] {
    OP_READ    = 4'd0,
    OP_CMP_S   = 4'd1,
    OP_CMP_U   = 4'd2,
    OP_CMP_SI  = 4'd3,
    OP_CMP_UI  = 4'd4,
    OP_FCOPY   = 4'd5,
    OP_MWRITE  = 4'd6,
    OP_STCOND  = 4'd7,
    OP_B_AND   = 4'd8,
    OP_B_OR    = 4'd9,
    OP_B_NAND  = 4'd10,
    OP_B_XOR   = 4'd11,
    OP_B_NOR   = 4'd12,
    OP_B_EQV   = 4'd13,
    OP_B_ANDC  = 4'd14,
    OP_B_ORC   = 4'd15
  } op_e;

  typedef enum logic [2:0] {
    FK_NONE,
    FK_CMP,
    FK_COPY,
    FK_STORE,
    FK_MASK
  } fkind_e;

  // Two-input Boolean function selected by the low three op bits.
  function automatic logic bit_fn(input logic [2:0] f, input logic x, input logic y);
    case (f)
      3'd0:    return x & y;
      3'd1:    return x | y;
      3'd2:    return ~(x & y);
      3'd3:    return x ^ y;
      3'd4:    return ~(x | y);
      3'd5:    return ~(x ^ y);
      3'd6:    return x & ~y;
      default: return x | ~y;
    endcase
  endfunction

endpackage

// File: rtl/crf_compare.sv
module crf_compare #(
  parameter int DW    = 32,
  parameter int IMM_W = 16,
  parameter int FLD_W = 4
) (
  input  logic             is_signed,
  input  logic             use_imm,
  input  logic [DW-1:0]    a,
  input  logic [DW-1:0]    b,
  input  logic [IMM_W-1:0] imm,
  input  logic             so,
  output logic [FLD_W-1:0] fld
);

  logic [DW-1:0] rhs;
  logic          lt, eq, gt;

  always_comb begin
    if (!use_imm)
      rhs = b;
    else if (is_signed)
      rhs = {{(DW-IMM_W){imm[IMM_W-1]}}, imm};
    else
      rhs = {{(DW-IMM_W){1'b0}}, imm};
  end

  assign lt = is_signed ? ($signed(a) < $signed(rhs)) : (a < rhs);
  assign eq = (a == rhs);
  assign gt = !lt && !eq;

  always_comb begin
    fld          = '0;
    fld[FLD_W-1] = lt;
    fld[FLD_W-2] = gt;
    fld[FLD_W-3] = eq;
    fld[0]       = so;
  end

endmodule

// File: rtl/crf_bitop.sv
module crf_bitop #(
  parameter int CR_W   = 32,
  parameter int BSEL_W = 5
) (
  input  logic [2:0]        fn,
  input  logic [CR_W-1:0]   cr,
  input  logic [BSEL_W-1:0] ba,
  input  logic [BSEL_W-1:0] bb,
  input  logic [BSEL_W-1:0] bt,
  output logic [CR_W-1:0]   en,
  output logic [CR_W-1:0]   data
);

  logic x, y, res;

  // Bit number n counts from the MSB: physical index CR_W-1-n.
  assign x   = cr[CR_W-1-int'(ba)];
  assign y   = cr[CR_W-1-int'(bb)];
  assign res = crf_pkg::bit_fn(fn, x, y);

  assign en   = CR_W'(1) << (CR_W-1-int'(bt));
  assign data = {CR_W{res}};

endmodule

// File: rtl/crf_fields.sv
module crf_fields #(
  parameter int NFLD  = 8,
  parameter int FLD_W = 4,
  localparam int CR_W   = NFLD * FLD_W,
  localparam int FSEL_W = $clog2(NFLD)
) (
  input  crf_pkg::fkind_e   kind,
  input  logic [CR_W-1:0]   cr,
  input  logic [CR_W-1:0]   src_reg,
  input  logic [FLD_W-1:0]  cmp_fld,
  input  logic [FSEL_W-1:0] fld_dst,
  input  logic [FSEL_W-1:0] fld_src,
  input  logic [NFLD-1:0]   mask,
  input  logic              ok,
  input  logic              so,
  output logic [CR_W-1:0]   en,
  output logic [CR_W-1:0]   data
);

  logic [FLD_W-1:0] copy_fld;
  logic [FLD_W-1:0] store_fld;

  assign copy_fld = cr[(NFLD-1-int'(fld_src))*FLD_W +: FLD_W];

  always_comb begin
    store_fld    = '0;
    store_fld[1] = ok;
    store_fld[0] = so;
  end

  // Physical group g holds logical field NFLD-1-g.
  for (genvar g = 0; g < NFLD; g++) begin : g_grp
    logic             g_en;
    logic [FLD_W-1:0] g_dat;
    logic             hit;

    assign hit = (fld_dst == FSEL_W'(NFLD-1-g));

    always_comb begin
      g_en  = 1'b0;
      g_dat = '0;
      case (kind)
        crf_pkg::FK_CMP:   begin g_en = hit;          g_dat = cmp_fld;                   end
        crf_pkg::FK_COPY:  begin g_en = hit;          g_dat = copy_fld;                  end
        crf_pkg::FK_STORE: begin g_en = (g == NFLD-1); g_dat = store_fld;                end
        crf_pkg::FK_MASK:  begin g_en = mask[g];      g_dat = src_reg[g*FLD_W +: FLD_W]; end
        default:           begin g_en = 1'b0;         g_dat = '0;                        end
      endcase
    end

    assign en[g*FLD_W +: FLD_W]   = {FLD_W{g_en}};
    assign data[g*FLD_W +: FLD_W] = g_dat;
  end

endmodule

// File: rtl/cond_reg_unit.sv
module cond_reg_unit #(
  parameter int NFLD  = 8,
  parameter int FLD_W = 4,
  parameter int IMM_W = 16,
  localparam int CR_W   = NFLD * FLD_W,
  localparam int FSEL_W = $clog2(NFLD),
  localparam int BSEL_W = $clog2(CR_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [3:0]        op_code,
  input  logic [CR_W-1:0]   opnd_a,
  input  logic [CR_W-1:0]   opnd_b,
  input  logic [IMM_W-1:0]  imm16,
  input  logic [FSEL_W-1:0] fld_dst,
  input  logic [FSEL_W-1:0] fld_src,
  input  logic [BSEL_W-1:0] bit_dst,
  input  logic [BSEL_W-1:0] bit_a,
  input  logic [BSEL_W-1:0] bit_b,
  input  logic [NFLD-1:0]   fld_mask,
  input  logic              sum_ovf,
  input  logic              store_ok,
  output logic [CR_W-1:0]   cr_out
);

  import crf_pkg::*;

  op_e              op;
  fkind_e           kind;
  logic             is_bit;
  logic             cmp_signed, cmp_imm;
  logic [FLD_W-1:0] cmp_fld;
  logic [CR_W-1:0]  fld_en, fld_data, bit_en, bit_data;
  logic [CR_W-1:0]  wr_en, wr_data;
  logic [CR_W-1:0]  cr_q;

  assign op     = op_e'(op_code);
  assign is_bit = op_code[3];

  always_comb begin
    cmp_signed = 1'b0;
    cmp_imm    = 1'b0;
    kind       = FK_NONE;
    case (op)
      OP_CMP_S:  begin kind = FK_CMP; cmp_signed = 1'b1; end
      OP_CMP_U:  begin kind = FK_CMP;                    end
      OP_CMP_SI: begin kind = FK_CMP; cmp_signed = 1'b1; cmp_imm = 1'b1; end
      OP_CMP_UI: begin kind = FK_CMP; cmp_imm = 1'b1;    end
      OP_FCOPY:  kind = FK_COPY;
      OP_MWRITE: kind = FK_MASK;
      OP_STCOND: kind = FK_STORE;
      default:   kind = FK_NONE;
    endcase
  end

  crf_compare #(.DW(CR_W), .IMM_W(IMM_W), .FLD_W(FLD_W)) u_cmp (
    .is_signed (cmp_signed),
    .use_imm   (cmp_imm),
    .a         (opnd_a),
    .b         (opnd_b),
    .imm       (imm16),
    .so        (sum_ovf),
    .fld       (cmp_fld)
  );

  crf_fields #(.NFLD(NFLD), .FLD_W(FLD_W)) u_fld (
    .kind     (kind),
    .cr       (cr_q),
    .src_reg  (opnd_a),
    .cmp_fld  (cmp_fld),
    .fld_dst  (fld_dst),
    .fld_src  (fld_src),
    .mask     (fld_mask),
    .ok       (store_ok),
    .so       (sum_ovf),
    .en       (fld_en),
    .data     (fld_data)
  );

  crf_bitop #(.CR_W(CR_W), .BSEL_W(BSEL_W)) u_bit (
    .fn   (op_code[2:0]),
    .cr   (cr_q),
    .ba   (bit_a),
    .bb   (bit_b),
    .bt   (bit_dst),
    .en   (bit_en),
    .data (bit_data)
  );

  assign wr_en   = !op_valid ? '0 : (is_bit ? bit_en : fld_en);
  assign wr_data = is_bit ? bit_data : fld_data;

  always_ff @(posedge clk) begin
    if (!rst_n)
      cr_q <= '0;
    else
      cr_q <= (cr_q & ~wr_en) | (wr_data & wr_en);
  end

  assign cr_out = cr_q;

endmodule

// File: rtl/crf_checks.sv
module crf_checks #(
  parameter int NFLD  = 8,
  parameter int FLD_W = 4,
  localparam int CR_W = NFLD * FLD_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             op_valid,
  input logic [3:0]       op_code,
  input logic [NFLD-1:0]  fld_mask,
  input logic             sum_ovf,
  input logic [CR_W-1:0]  cr_out,
  input logic [CR_W-1:0]  wr_en,
  input logic [FLD_W-1:0] cmp_fld
);

  logic is_cmp;
  assign is_cmp = (op_code >= 4'd1) && (op_code <= 4'd4);

  AST_RESET_ZERO: assert property (@(posedge clk) !rst_n |=> cr_out == '0); // R1

  AST_CMP_ONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && is_cmp) |-> $onehot(cmp_fld[FLD_W-1:FLD_W-3])); // R2

  AST_CMP_SO_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && is_cmp) |-> (cmp_fld[0] == sum_ovf)); // R2

  AST_CMP_ONE_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && is_cmp) |-> ($countones(wr_en) == FLD_W)); // R6

  AST_BIT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code[3]) |-> ($countones(wr_en) == 1)); // R7

  AST_MASK_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 4'd6) |-> ($countones(wr_en) == FLD_W * $countones(fld_mask))); // R9

  AST_STORE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 4'd7) |=>
      (cr_out[CR_W-FLD_W-1:0] == $past(cr_out[CR_W-FLD_W-1:0])) && (cr_out[CR_W-1:CR_W-2] == 2'b00)); // R10

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_valid || op_code == 4'd0) |=> $stable(cr_out)); // R11

endmodule

bind cond_reg_unit crf_checks #(.NFLD(NFLD), .FLD_W(FLD_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .op_valid (op_valid),
  .op_code  (op_code),
  .fld_mask (fld_mask),
  .sum_ovf  (sum_ovf),
  .cr_out   (cr_out),
  .wr_en    (wr_en),
  .cmp_fld  (cmp_fld)
);

// File: tb/cond_reg_unit_test.sv
module cond_reg_unit_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [3:0]  op_code = '0;
  logic [31:0] opnd_a = '0, opnd_b = '0;
  logic [15:0] imm16 = '0;
  logic [2:0]  fld_dst = '0, fld_src = '0;
  logic [4:0]  bit_dst = '0, bit_a = '0, bit_b = '0;
  logic [7:0]  fld_mask = '0;
  logic        sum_ovf = 1'b0, store_ok = 1'b0;
  logic [31:0] cr_out;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  cond_reg_unit uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .imm16(imm16),
    .fld_dst(fld_dst), .fld_src(fld_src),
    .bit_dst(bit_dst), .bit_a(bit_a), .bit_b(bit_b),
    .fld_mask(fld_mask), .sum_ovf(sum_ovf), .store_ok(store_ok),
    .cr_out(cr_out)
  );

  typedef struct packed {
    logic [3:0]  op;
    logic [31:0] a;
    logic [31:0] b;
    logic [15:0] imm;
    logic [2:0]  fd;
    logic [2:0]  fs;
    logic [4:0]  bd;
    logic [4:0]  ba;
    logic [4:0]  bb;
    logic [7:0]  mask;
    logic        so;
    logic        ok;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VECS [NV] = '{
    '{4'd6, 32'h12345678, 32'h0, 16'h0, 3'd0, 3'd0, 5'd0, 5'd0, 5'd0, 8'hFF, 1'b0, 1'b0, 32'h12345678, 4'd9},  // R9 all groups
    '{4'd6, 32'hAAAAAAAA, 32'h0, 16'h0, 3'd0, 3'd0, 5'd0, 5'd0, 5'd0, 8'h05, 1'b0, 1'b0, 32'h12345A7A, 4'd9},  // R9 groups 0,2
    '{4'd1, 32'hFFFFFFFF, 32'h1, 16'h0, 3'd0, 3'd0, 5'd0, 5'd0, 5'd0, 8'h00, 1'b0, 1'b0, 32'h82345A7A, 4'd3},  // R3 R2 LT
    '{4'd2, 32'hFFFFFFFF, 32'h1, 16'h0, 3'd1, 3'd0, 5'd0, 5'd0, 5'd0, 8'h00, 1'b1, 1'b0, 32'h85345A7A, 4'd4},  // R4 R2 GT+SO
    '{4'd1, 32'h7,        32'h7, 16'h0, 3'd7, 3'd0, 5'd0, 5'd0, 5'd0, 8'h00, 1'b0, 1'b0, 32'h85345A72, 4'd6},  // R6 field 7
    '{4'd3, 32'hFFFF8000, 32'h0, 16'h8000, 3'd3, 3'd0, 5'd0, 5'd0, 5'd0, 8'h00, 1'b1, 1'b0, 32'h85335A72, 4'd5}, // R5 sext EQ
    '{4'd4, 32'h00010000, 32'h0, 16'h8000, 3'd4, 3'd0, 5'd0, 5'd0, 5'd0, 8'h00, 1'b0, 1'b0, 32'h85334A72, 4'd5}, // R5 zext GT
    '{4'd3, 32'h5,        32'h0, 16'hFFFF, 3'd5, 3'd0, 5'd0, 5'd0, 5'd0, 8'h00, 1'b0, 1'b0, 32'h85334472, 4'd5}, // R5 5 > -1
    '{4'd5, 32'h0,        32'h0, 16'h0, 3'd7, 3'd0, 5'd0, 5'd0, 5'd0, 8'h00, 1'b0, 1'b0, 32'h85334478, 4'd8},  // R8 copy 0->7
    '{4'd8,  32'h0, 32'h0, 16'h0, 3'd0, 3'd0, 5'd31, 5'd0, 5'd5, 8'h00, 1'b0, 1'b0, 32'h85334479, 4'd7},       // R7 AND
    '{4'd9,  32'h0, 32'h0, 16'h0, 3'd0, 3'd0, 5'd0,  5'd1, 5'd2, 8'h00, 1'b0, 1'b0, 32'h05334479, 4'd7},       // R7 OR
    '{4'd10, 32'h0, 32'h0, 16'h0, 3'd0, 3'd0, 5'd1,  5'd0, 5'd5, 8'h00, 1'b0, 1'b0, 32'h45334479, 4'd7},       // R7 NAND
    '{4'd11, 32'h0, 32'h0, 16'h0, 3'd0, 3'd0, 5'd8,  5'd4, 5'd5, 8'h00, 1'b0, 1'b0, 32'h45B34479, 4'd7},       // R7 XOR
    '{4'd12, 32'h0, 32'h0, 16'h0, 3'd0, 3'd0, 5'd5,  5'd1, 5'd2, 8'h00, 1'b0, 1'b0, 32'h41B34479, 4'd7},       // R7 NOR
    '{4'd13, 32'h0, 32'h0, 16'h0, 3'd0, 3'd0, 5'd12, 5'd2, 5'd3, 8'h00, 1'b0, 1'b0, 32'h41BB4479, 4'd7},       // R7 EQV
    '{4'd14, 32'h0, 32'h0, 16'h0, 3'd0, 3'd0, 5'd16, 5'd1, 5'd2, 8'h00, 1'b0, 1'b0, 32'h41BBC479, 4'd7},       // R7 ANDC
    '{4'd15, 32'h0, 32'h0, 16'h0, 3'd0, 3'd0, 5'd17, 5'd2, 5'd1, 8'h00, 1'b0, 1'b0, 32'h41BB8479, 4'd7},       // R7 ORC
    '{4'd7, 32'h0, 32'h0, 16'h0, 3'd0, 3'd0, 5'd0, 5'd0, 5'd0, 8'h00, 1'b0, 1'b1, 32'h21BB8479, 4'd10},        // R10 ok
    '{4'd7, 32'h0, 32'h0, 16'h0, 3'd0, 3'd0, 5'd0, 5'd0, 5'd0, 8'h00, 1'b1, 1'b0, 32'h11BB8479, 4'd10},        // R10 fail+SO
    '{4'd7, 32'h0, 32'h0, 16'h0, 3'd0, 3'd0, 5'd0, 5'd0, 5'd0, 8'h00, 1'b1, 1'b1, 32'h31BB8479, 4'd10},        // R10 ok+SO
    '{4'd0, 32'hFFFFFFFF, 32'h0, 16'h0, 3'd0, 3'd0, 5'd0, 5'd0, 5'd0, 8'hFF, 1'b0, 1'b0, 32'h31BB8479, 4'd11}, // R11 read
    '{4'd6, 32'hFFFFFFFF, 32'h0, 16'h0, 3'd0, 3'd0, 5'd0, 5'd0, 5'd0, 8'h00, 1'b0, 1'b0, 32'h31BB8479, 4'd9},  // R9 zero mask
    '{4'd2, 32'h80000000, 32'h7FFFFFFF, 16'h0, 3'd6, 3'd0, 5'd0, 5'd0, 5'd0, 8'h00, 1'b0, 1'b0, 32'h31BB8449, 4'd4}, // R4 GT
    '{4'd1, 32'h80000000, 32'h7FFFFFFF, 16'h0, 3'd6, 3'd0, 5'd0, 5'd0, 5'd0, 8'h00, 1'b0, 1'b0, 32'h31BB8489, 4'd3}  // R3 LT
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: cr_out=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic drive(input vec_t v, input logic valid);
    op_valid = valid;
    op_code  = v.op;
    opnd_a   = v.a;
    opnd_b   = v.b;
    imm16    = v.imm;
    fld_dst  = v.fd;
    fld_src  = v.fs;
    bit_dst  = v.bd;
    bit_a    = v.ba;
    bit_b    = v.bb;
    fld_mask = v.mask;
    sum_ovf  = v.so;
    store_ok = v.ok;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    vec_t d;
    repeat (3) @(negedge clk);
    check("R1 reset", cr_out, 32'h0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VECS[i], 1'b1);
      @(negedge clk);
      op_valid = 1'b0;
      check($sformatf("R%0d vector %0d", VECS[i].req, i), cr_out, VECS[i].exp);
    end

    // R11: during the accepting cycle the old value is still on cr_out
    d = '{4'd6, 32'h0, 32'h0, 16'h0, 3'd0, 3'd0, 5'd0, 5'd0, 5'd0, 8'hFF, 1'b0, 1'b0, 32'h0, 4'd11};
    @(negedge clk);
    drive(d, 1'b1);
    #3;
    check("R11 same-cycle read", cr_out, 32'h31BB8489);
    @(negedge clk);
    op_valid = 1'b0;
    check("R11 after edge", cr_out, 32'h0);

    // R11: op_valid low suppresses a masked write
    d.a = 32'hFFFFFFFF;
    @(negedge clk);
    drive(d, 1'b0);
    @(negedge clk);
    check("R11 invalid ignored", cr_out, 32'h0);

    // R6: compare into field 0 with all other fields set
    @(negedge clk);
    drive(d, 1'b1);
    @(negedge clk);
    d = '{4'd2, 32'h3, 32'h3, 16'h0, 3'd0, 3'd0, 5'd0, 5'd0, 5'd0, 8'h00, 1'b0, 1'b0, 32'h0, 4'd6};
    drive(d, 1'b1);
    @(negedge clk);
    op_valid = 1'b0;
    check("R6 others kept", cr_out, 32'h2FFFFFFF);

    // R1: reset in mid-run clears the register
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 mid-run reset", cr_out, 32'h0);
    rst_n = 1'b1;

    finish_run();
  end

  initial begin
    repeat (2000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

endmodule